// File: doc/BRIEF.md
# UART Receive Path with Break and Address Filtering

This block is the receive half of an asynchronous serial port. It watches one serial input line and uses a baud tick that runs at an oversampling rate (OVS ticks per bit, 16 by default). For each character it finds the start edge, samples every bit at its centre and assembles the frame. Frames run least significant bit first and carry 8 data bits, an optional parity or address-flag bit and a stop bit. Accepted bytes go into a small receive FIFO that is read one byte at a time.

Two configurable behaviours change what reaches the FIFO. In nine-bit mode the extra bit tags a byte as an address. Only an address that matches a programmed value, with a mask applied, opens the node to the data bytes that follow it. A line held low for a long stretch is reported as a break and stores no byte. A watermark interrupt tells software when enough bytes are waiting. A configuration bit places that interrupt either at the centre of the stop bit or half a bit later, at its end. Sticky error flags report parity errors, framing errors and FIFO overrun. The flags stay set until software pulses a clear input.

Top module: `uart_rx_path`

## Requirements
- R1: After reset, idle is 1, and rx_avail, irq_wm, parity_err, frame_err, overflow, break_rx and addr_match are all 0.
- R2: A frame is a low start bit, then DW data bits least significant first, then an optional extra bit, then a high stop bit, each OVS baud ticks long. Received bytes come out of the read port in arrival order, at any baud tick rate.
- R3: cfg_par selects the parity: 0 or 3 is none, 1 is even (the ones across data and parity bit add up to an even count) and 2 is odd. A mismatch sets parity_err, and the byte is still stored. Parity is not used in nine-bit mode.
- R4: A stop bit sampled low on a frame that has at least one high bit sets frame_err, and the byte is still stored.
- R5: A low line lasting BRK_BITS (11) bit times, counted from the start bit, sets break_rx, stores no byte and does not set frame_err. An all-zero frame whose line returns high before that count sets frame_err and stores 0x00.
- R6: The FIFO holds DEPTH (8) bytes. A byte that arrives while the FIFO is full is dropped, and overflow is set and stays set.
- R7: irq_wm is 1 while the FIFO holds at least cfg_wm+1 bytes, and 0 otherwise.
- R8: With cfg_stop_end=0 the byte, and so irq_wm, arrives within about one bit time of the start of the stop bit. With cfg_stop_end=1 it arrives exactly OVS/2 baud ticks later.
- R9: With cfg_nine=1, a ninth bit of 1 marks the byte as an address. A matching address is stored and sets addr_match. Data bytes (ninth bit 0) are stored only while addr_match is 1. A non-matching address clears addr_match and is not stored.
- R10: An address matches when it equals cfg_addr in every bit where cfg_addr_mask is 1. Bits where the mask is 0 are ignored.
- R11: While rx_en is 0 the receiver is stopped, even in the middle of a frame. idle reads 1 and no byte is stored.
- R12: A one-cycle pulse on flag_clr clears parity_err, frame_err, break_rx and overflow, unless a new event sets them in the same cycle.
- R13: A pulse on rd_en removes the oldest byte, and the byte appears on rd_data one cycle later. rd_en has no effect while the FIFO is empty, and rd_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| baud_tick | input | 1 | Oversampling tick, OVS per bit time |
| rxd | input | 1 | Serial input line, idle high |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_nine | input | 1 | Nine-bit address mode |
| cfg_addr | input | DW | Node address |
| cfg_addr_mask | input | DW | Address compare mask, 1 = compare bit |
| cfg_wm | input | log2(DEPTH) | Watermark level minus one |
| cfg_stop_end | input | 1 | 0: deliver at stop-bit centre, 1: at stop-bit end |
| flag_clr | input | 1 | Clears the sticky flags |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | DW | Byte popped by the last rd_en |
| rx_avail | output | 1 | FIFO is not empty |
| irq_wm | output | 1 | FIFO level has reached the watermark |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |
| overflow | output | 1 | Sticky overrun |
| break_rx | output | 1 | Sticky break received |
| addr_match | output | 1 | Node is currently addressed (nine-bit mode) |
| idle | output | 1 | Receiver is waiting for a start bit |

## Verification
The bench gives one baud tick per clock, so a bit lasts 16 cycles. The byte enters the FIFO about three cycles after the stop bit is sampled at its centre. rx_avail follows one cycle later and irq_wm one cycle after that. rd_data is valid one cycle after rd_en. Bytes are therefore compared through a scoreboard at the moment they pop out, not at fixed times, and sticky flags are sampled only after two idle bit times have passed. The stop-bit interrupt position is measured in cycles from the start of the stop bit. The check only bounds the centre case loosely, but requires the end-of-stop case to be exactly eight cycles later, which keeps the check independent of the synchroniser depth.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_TAIL, ST_BRKW, ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_RSVD = 2'd3
  } par_mode_e;
endpackage

// File: rtl/rxp_framer.sv
module rxp_framer
  import rxp_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int BRK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_nine,
  input  logic          cfg_stop_end,
  output logic          fr_valid,
  output logic [DW-1:0] fr_data,
  output logic          fr_flag9,
  output logic          fr_perr,
  output logic          fr_ferr,
  output logic          brk_pulse,
  output logic          idle
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BW   = $clog2(DW + 1);
  localparam int LW   = $clog2(DW + BRK_BITS + 4);

  logic [1:0]    sync;
  logic          rx_s;
  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn, last_bit;
  logic [DW:0]   sr;
  logic [LW-1:0] lowcnt, lc_next, frame_lows;
  logic          par_on, ext, perr_calc, cnt_full, cnt_half;

  assign rx_s       = sync[1];
  assign par_on     = !cfg_nine && (cfg_par == PAR_EVEN || cfg_par == PAR_ODD);
  assign ext        = cfg_nine | par_on;
  assign last_bit   = BW'(DW - 1) + BW'(ext);
  assign frame_lows = LW'(DW + 2) + LW'(ext);
  assign lc_next    = rx_s ? '0 : ((&lowcnt) ? lowcnt : lowcnt + 1'b1);
  assign cnt_full   = (cnt == CW'(OVS - 1));
  assign cnt_half   = (cnt == CW'(HALF - 1));
  assign perr_calc  = par_on && ((^sr) != (cfg_par == PAR_ODD));
  assign idle       = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync      <= 2'b11;
      st        <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sr        <= '0;
      lowcnt    <= '0;
      fr_valid  <= 1'b0;
      fr_data   <= '0;
      fr_flag9  <= 1'b0;
      fr_perr   <= 1'b0;
      fr_ferr   <= 1'b0;
      brk_pulse <= 1'b0;
    end else begin
      sync      <= {sync[0], rxd};
      fr_valid  <= 1'b0;
      brk_pulse <= 1'b0;
      if (!en) begin
        st <= ST_IDLE;
      end else if (tick) begin
        case (st)
          ST_IDLE: if (!rx_s) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: if (cnt_half) begin
            cnt <= '0;
            if (!rx_s) begin
              st     <= ST_DATA;
              bitn   <= '0;
              lowcnt <= LW'(1);
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_DATA: if (cnt_full) begin
            cnt      <= '0;
            sr[bitn] <= rx_s;
            lowcnt   <= lc_next;
            bitn     <= bitn + 1'b1;
            if (bitn == last_bit) st <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_STOP: if (cnt_full) begin
            cnt <= '0;
            if (rx_s) begin
              if (cfg_stop_end) begin
                st <= ST_TAIL;
              end else begin
                fr_valid <= 1'b1;
                fr_data  <= sr[DW-1:0];
                fr_flag9 <= sr[DW] & cfg_nine;
                fr_perr  <= perr_calc;
                fr_ferr  <= 1'b0;
                st       <= ST_IDLE;
              end
            end else if (lc_next == frame_lows) begin
              if (lc_next >= LW'(BRK_BITS)) begin
                brk_pulse <= 1'b1;
                st        <= ST_HOLD;
              end else begin
                lowcnt <= lc_next;
                st     <= ST_BRKW;
              end
            end else begin
              fr_valid <= 1'b1;
              fr_data  <= sr[DW-1:0];
              fr_flag9 <= sr[DW] & cfg_nine;
              fr_perr  <= perr_calc;
              fr_ferr  <= 1'b1;
              st       <= ST_HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_TAIL: if (cnt_half) begin
            cnt      <= '0;
            fr_valid <= 1'b1;
            fr_data  <= sr[DW-1:0];
            fr_flag9 <= sr[DW] & cfg_nine;
            fr_perr  <= perr_calc;
            fr_ferr  <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_BRKW: if (cnt_full) begin
            cnt <= '0;
            if (!rx_s) begin
              lowcnt <= lc_next;
              if (lc_next >= LW'(BRK_BITS)) begin
                brk_pulse <= 1'b1;
                st        <= ST_HOLD;
              end
            end else begin
              fr_valid <= 1'b1;
              fr_data  <= '0;
              fr_flag9 <= 1'b0;
              fr_perr  <= perr_calc;
              fr_ferr  <= 1'b1;
              st       <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_HOLD: if (rx_s) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R11
  en_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st == ST_IDLE) && !fr_valid);

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && st == ST_START && cnt_half && rx_s) |=> (st == ST_IDLE));

  // R5
  brk_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> !fr_valid && (st == ST_HOLD));
endmodule

// File: rtl/rxp_accept.sv
module rxp_accept #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fr_valid,
  input  logic [DW-1:0] fr_data,
  input  logic          fr_flag9,
  input  logic          fr_perr,
  input  logic          fr_ferr,
  input  logic          brk_pulse,
  input  logic          cfg_nine,
  input  logic [DW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_mask,
  input  logic          fifo_full,
  input  logic          flag_clr,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          addr_match,
  output logic          parity_err,
  output logic          frame_err,
  output logic          break_rx,
  output logic          overflow
);
  logic match_q, hit, keep, ovf_set;

  assign hit        = (((fr_data ^ cfg_addr) & cfg_mask) == '0);
  assign keep       = !cfg_nine || (fr_flag9 ? hit : match_q);
  assign ovf_set    = push && fifo_full;
  assign addr_match = match_q && cfg_nine;

  always_ff @(posedge clk) begin
    if (rst) begin
      push       <= 1'b0;
      push_data  <= '0;
      match_q    <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_rx   <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      push <= fr_valid && keep;
      if (fr_valid) push_data <= fr_data;
      if (fr_valid && cfg_nine && fr_flag9) match_q <= hit;

      if (fr_valid && fr_perr) parity_err <= 1'b1;
      else if (flag_clr)       parity_err <= 1'b0;
      if (fr_valid && fr_ferr) frame_err <= 1'b1;
      else if (flag_clr)       frame_err <= 1'b0;
      if (brk_pulse)           break_rx <= 1'b1;
      else if (flag_clr)       break_rx <= 1'b0;
      if (ovf_set)             overflow <= 1'b1;
      else if (flag_clr)       overflow <= 1'b0;
    end
  end

  // R9
  addr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && cfg_nine && fr_flag9 && !hit) |=> !push && !match_q);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full) |=> overflow);

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !fr_valid && !brk_pulse && !(push && fifo_full))
      |=> !parity_err && !frame_err && !break_rx && !overflow);
endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop_req,
  input  logic [$clog2(DEPTH):0]   lvl,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     avail,
  output logic                     irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CNW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CNW'(DEPTH));
  assign avail   = (count != '0);
  assign do_push = push && !full;
  assign do_pop  = pop_req && avail;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop) begin
        rptr    <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      irq <= (count >= lvl);
    end
  end

  // R13
  pop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && count != '0 && !push) |=> count == $past(count) - 1'b1);

  // R7
  irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> !irq);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop_req) |=> full);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path #(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int DEPTH    = 8,
  parameter int BRK_BITS = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_en,
  input  logic                       baud_tick,
  input  logic                       rxd,
  input  logic [1:0]                 cfg_par,
  input  logic                       cfg_nine,
  input  logic [DW-1:0]              cfg_addr,
  input  logic [DW-1:0]              cfg_addr_mask,
  input  logic [$clog2(DEPTH)-1:0]   cfg_wm,
  input  logic                       cfg_stop_end,
  input  logic                       flag_clr,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       rx_avail,
  output logic                       irq_wm,
  output logic                       parity_err,
  output logic                       frame_err,
  output logic                       overflow,
  output logic                       break_rx,
  output logic                       addr_match,
  output logic                       idle
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CNW = AW + 1;

  logic          fr_valid, fr_flag9, fr_perr, fr_ferr, brk_pulse;
  logic [DW-1:0] fr_data, push_data;
  logic          push, fifo_full;
  logic [CNW-1:0] lvl, count;

  assign lvl = CNW'(cfg_wm) + 1'b1;

  rxp_framer #(.OVS(OVS), .DW(DW), .BRK_BITS(BRK_BITS)) u_framer (
    .clk, .rst, .en(rx_en), .tick(baud_tick), .rxd,
    .cfg_par, .cfg_nine, .cfg_stop_end,
    .fr_valid, .fr_data, .fr_flag9, .fr_perr, .fr_ferr, .brk_pulse, .idle
  );

  rxp_accept #(.DW(DW)) u_accept (
    .clk, .rst, .fr_valid, .fr_data, .fr_flag9, .fr_perr, .fr_ferr, .brk_pulse,
    .cfg_nine, .cfg_addr, .cfg_mask(cfg_addr_mask), .fifo_full, .flag_clr,
    .push, .push_data, .addr_match, .parity_err, .frame_err, .break_rx, .overflow
  );

  rxp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst, .push, .push_data, .pop_req(rd_en), .lvl,
    .rd_data, .count, .full(fifo_full), .avail(rx_avail), .irq(irq_wm)
  );
endmodule

// File: tb/sim_uart_rx_path.sv
module sim_uart_rx_path;
  localparam int OVS = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_en, baud_tick, rxd, cfg_nine, cfg_stop_end, flag_clr, rd_en;
  logic [1:0] cfg_par;
  logic [7:0] cfg_addr, cfg_addr_mask, rd_data;
  logic [2:0] cfg_wm;
  logic rx_avail, irq_wm, parity_err, frame_err, overflow, break_rx, addr_match, idle;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1, tc = 0;
  int stop_t = 0, irq_t = 0;
  bit auto_rd = 1'b1, irq_seen = 1'b0, done = 1'b0;
  logic [7:0] exp_q[$];

  uart_rx_path u0 (.*);

  always #5 clk = ~clk;

  initial forever begin @(posedge clk); cyc++; end

  initial begin
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      baud_tick = (tc == 0);
      tc = (tc + 1) % tick_div;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops bytes as they arrive and compares in order (R2, R13)
  initial begin
    rd_en = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_rd && rx_avail) begin
        logic [7:0] e;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R13 unexpected byte act=%02h exp=none", rd_data);
        end else begin
          e = exp_q.pop_front();
          if (rd_data !== e) begin
            errors++;
            $display("FAIL R2 byte order act=%02h exp=%02h", rd_data, e);
          end
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq_wm && !irq_seen) begin irq_seen = 1'b1; irq_t = cyc; end
  end

  task automatic put_bit(input logic b);
    rxd = b;
    repeat (OVS * tick_div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit has_x, input bit x, input bit stop_v);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(d[i]);
    if (has_x) put_bit(x);
    stop_t = cyc;
    put_bit(stop_v);
    rxd = 1'b1;
    repeat (2 * OVS * tick_div) @(negedge clk);
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] held;
    int d0, d1;
    rx_en = 1'b1; rxd = 1'b1; cfg_par = 2'd0; cfg_nine = 1'b0; cfg_addr = 8'h00;
    cfg_addr_mask = 8'h00; cfg_wm = 3'd0; cfg_stop_end = 1'b0; flag_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(idle === 1'b1, "R1 idle", idle, 1);
    chk(rx_avail === 1'b0 && irq_wm === 1'b0, "R1 fifo outputs", {rx_avail, irq_wm}, 0);
    chk({parity_err, frame_err, overflow, break_rx, addr_match} === 5'b0, "R1 flags",
        {parity_err, frame_err, overflow, break_rx, addr_match}, 0);

    // R2 several byte patterns, one tick per clock
    foreach (exp_q[i]) ;
    exp_q.push_back(8'hA5); send(8'hA5, 0, 0, 1);
    exp_q.push_back(8'h3C); send(8'h3C, 0, 0, 1);
    exp_q.push_back(8'hFF); send(8'hFF, 0, 0, 1);
    exp_q.push_back(8'h01); send(8'h01, 0, 0, 1);
    settle();
    chk(exp_q.size() == 0, "R2 all bytes received", exp_q.size(), 0);
    chk({parity_err, frame_err} === 2'b0, "R2 no errors", {parity_err, frame_err}, 0);

    // R13 rd_en on empty FIFO has no effect
    auto_rd = 1'b0;
    held = rd_data;
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    chk(rd_data === held && rx_avail === 1'b0, "R13 pop on empty", rd_data, held);
    auto_rd = 1'b1;

    // R2 slower tick rate
    tick_div = 3;
    exp_q.push_back(8'h96); send(8'h96, 0, 0, 1);
    exp_q.push_back(8'h5A); send(8'h5A, 0, 0, 1);
    settle();
    chk(exp_q.size() == 0, "R2 divided tick", exp_q.size(), 0);
    tick_div = 1;

    // R3 even then odd parity
    cfg_par = 2'd1;
    exp_q.push_back(8'h37); send(8'h37, 1, ^8'h37, 1);
    settle();
    chk(parity_err === 1'b0, "R3 even good", parity_err, 0);
    exp_q.push_back(8'h37); send(8'h37, 1, ~^8'h37, 1);
    settle();
    chk(parity_err === 1'b1 && exp_q.size() == 0, "R3 even bad stored", parity_err, 1);
    clear_flags();
    chk(parity_err === 1'b0, "R12 clear parity", parity_err, 0);
    cfg_par = 2'd2;
    exp_q.push_back(8'hC3); send(8'hC3, 1, ~^8'hC3, 1);
    settle();
    chk(parity_err === 1'b0, "R3 odd good", parity_err, 0);
    exp_q.push_back(8'hC1); send(8'hC1, 1, ^8'hC1, 1);
    settle();
    chk(parity_err === 1'b1, "R3 odd bad", parity_err, 1);
    clear_flags();
    cfg_par = 2'd0;

    // R4 framing error, byte kept
    exp_q.push_back(8'h42); send(8'h42, 0, 0, 0);
    settle();
    chk(frame_err === 1'b1 && exp_q.size() == 0, "R4 frame error", frame_err, 1);
    clear_flags();
    chk(frame_err === 1'b0, "R12 clear frame", frame_err, 0);

    // R5 break: 13 low bit times
    rxd = 1'b0; repeat (13 * OVS) @(negedge clk);
    rxd = 1'b1; repeat (3 * OVS) @(negedge clk);
    settle();
    chk(break_rx === 1'b1, "R5 break flag", break_rx, 1);
    chk(frame_err === 1'b0 && rx_avail === 1'b0, "R5 break stores nothing", {frame_err, rx_avail}, 0);
    clear_flags();
    chk(break_rx === 1'b0, "R12 clear break", break_rx, 0);
    // R5 ten low bits only: framing error, 0x00 stored
    exp_q.push_back(8'h00); send(8'h00, 0, 0, 0);
    settle();
    chk(frame_err === 1'b1 && break_rx === 1'b0 && exp_q.size() == 0, "R5 short low", frame_err, 1);
    clear_flags();

    // R7 watermark, R6 overflow
    auto_rd = 1'b0;
    cfg_wm = 3'd3;
    for (int i = 0; i < 3; i++) begin exp_q.push_back(8'h10 + 8'(i)); send(8'h10 + 8'(i), 0, 0, 1); end
    chk(irq_wm === 1'b0, "R7 below level", irq_wm, 0);
    exp_q.push_back(8'h13); send(8'h13, 0, 0, 1);
    chk(irq_wm === 1'b1, "R7 at level", irq_wm, 1);
    cfg_wm = 3'd7;
    for (int i = 4; i < 8; i++) begin exp_q.push_back(8'h10 + 8'(i)); send(8'h10 + 8'(i), 0, 0, 1); end
    chk(irq_wm === 1'b1 && overflow === 1'b0, "R7 full level no overflow", {irq_wm, overflow}, 2);
    send(8'hEE, 0, 0, 1);
    chk(overflow === 1'b1, "R6 overflow set", overflow, 1);
    auto_rd = 1'b1;
    settle();
    chk(exp_q.size() == 0 && rx_avail === 1'b0, "R6 dropped byte not stored", exp_q.size(), 0);
    chk(overflow === 1'b1, "R6 overflow sticky", overflow, 1);
    clear_flags();
    chk(overflow === 1'b0, "R12 clear overflow", overflow, 0);

    // R8 interrupt position
    auto_rd = 1'b0; cfg_wm = 3'd0;
    irq_seen = 1'b0; cfg_stop_end = 1'b0;
    exp_q.push_back(8'h6B); send(8'h6B, 0, 0, 1);
    d0 = irq_t - stop_t;
    chk(irq_seen && d0 >= OVS / 2 && d0 <= OVS + 4, "R8 mid-stop delay", d0, OVS);
    auto_rd = 1'b1; settle(); auto_rd = 1'b0;
    irq_seen = 1'b0; cfg_stop_end = 1'b1;
    exp_q.push_back(8'h4D); send(8'h4D, 0, 0, 1);
    d1 = irq_t - stop_t;
    chk(irq_seen && (d1 - d0) == OVS / 2, "R8 end-stop offset", d1 - d0, OVS / 2);
    auto_rd = 1'b1; settle();
    cfg_stop_end = 1'b0;

    // R9 address filtering, R10 mask
    cfg_nine = 1'b1; cfg_par = 2'd1; cfg_addr = 8'h5A; cfg_addr_mask = 8'hFF;
    send(8'h11, 1, 0, 1);
    settle();
    chk(rx_avail === 1'b0 && addr_match === 1'b0, "R9 data before address dropped", rx_avail, 0);
    exp_q.push_back(8'h5A); send(8'h5A, 1, 1, 1);
    chk(addr_match === 1'b1, "R9 address match", addr_match, 1);
    exp_q.push_back(8'h11); send(8'h11, 1, 0, 1);
    send(8'h33, 1, 1, 1);
    chk(addr_match === 1'b0, "R9 other address clears match", addr_match, 0);
    send(8'h22, 1, 0, 1);
    settle();
    chk(exp_q.size() == 0 && rx_avail === 1'b0 && parity_err === 1'b0, "R9 filtered stream", exp_q.size(), 0);
    cfg_addr = 8'h50; cfg_addr_mask = 8'hF0;
    exp_q.push_back(8'h57); send(8'h57, 1, 1, 1);
    chk(addr_match === 1'b1, "R10 masked match", addr_match, 1);
    exp_q.push_back(8'h99); send(8'h99, 1, 0, 1);
    send(8'h67, 1, 1, 1);
    chk(addr_match === 1'b0, "R10 unmasked bit differs", addr_match, 0);
    settle();
    chk(exp_q.size() == 0, "R10 stream", exp_q.size(), 0);
    cfg_nine = 1'b0; cfg_par = 2'd0;

    // R11 disabled receiver
    rx_en = 1'b0;
    @(negedge clk);
    chk(idle === 1'b1, "R11 idle when disabled", idle, 1);
    send(8'h77, 0, 0, 1);
    settle();
    chk(rx_avail === 1'b0, "R11 nothing stored", rx_avail, 0);
    rx_en = 1'b1;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    chk(idle === 1'b0, "R11 busy mid-frame", idle, 0);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(idle === 1'b1, "R11 stopped mid-frame", idle, 1);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    rx_en = 1'b1;
    settle();
    chk(rx_avail === 1'b0 && exp_q.size() == 0, "R11 aborted frame not stored", rx_avail, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule